// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 64 level-sensitive interrupt lines from on-chip peripherals. The lines are organised as two banks of 32, and the block presents them to a processor through a small 32-bit register bus. Every source has an enable bit and a routing bit. The routing bit sends the source either to the normal interrupt output or to the fast interrupt output. Both outputs are the registered OR of the sources that are pending on their path.

A programmable table of priority slots sets the order in which normal-path sources are served. Each slot names one source and carries a valid flag, and a lower slot index has precedence. Every cycle the block scans the table. A status word reports the winning source number, together with a flag that says whether any slot qualified. A separate wake output can bring an idle processor back. A control bit chooses whether any raw request wakes the processor or only enabled requests do.

Pending state follows the input levels directly. Nothing is latched, and software has no clear operation. To silence a source, software either removes the cause at the peripheral or disables the source.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset, all enable bits, routing bits, the wake-mode bit and every priority slot (valid and source number) are 0. irq_o, fiq_o, wake_o and bus_rdata are 0, and the status word reads 0.
- R2: Each bank has the same register layout. Bank 0 starts at offset 0x00 and bank 1 at offset 0x9C. Within a bank: 0x00 normal pending (read-only), 0x04 enable (1 = enabled), 0x08 routing (0 = normal, 1 = fast), 0x0C fast pending (read-only), 0x10 raw level (read-only). Bit i of a bank register is source 32·bank + i. A read returns its data on bus_rdata one cycle after bus_rd.
- R3: Normal pending = raw AND enable AND NOT routing. Fast pending = raw AND enable AND routing.
- R4: irq_o is the OR of all normal pending bits and fiq_o is the OR of all fast pending bits. Each one follows its pending vector with exactly one clock of delay.
- R5: Priority slot s is at 0x1C + 4·s for s < 32 and at 0xB0 + 4·(s − 32) for s ≥ 32. A slot stores bit 31 (valid) and bits 5:0 (source number). It reads back as exactly those bits, with every other bit zero.
- R6: The status word at 0x18 reports, in bits 30:16, the source held by the lowest-index slot that is valid and whose source has normal pending set. Bit 31 is then 1.
- R7: Sources routed to the fast path, disabled sources and invalid slots never win. When no slot qualifies, the status word is 0.
- R8: The status word is registered. It reflects a change in inputs or configuration one clock after that change.
- R9: Control bit 0 at 0x14 selects the wake mode. When it is 1, wake_o is the registered OR of raw AND enable. When it is 0, wake_o is the registered OR of raw.
- R10: Writes to the pending, raw and status offsets change nothing. Reads of offsets that are not mapped, including misaligned ones, return 0.
- R11: Pending is level-sensitive. When a source input falls, its pending bit and the outputs it drove clear one cycle later. When the input rises again, the pending bit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Level request from each source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to an idle processor |

## Verification
The bench loads the full priority table in reverse source order and then rewrites a few slots. It then compares the status word against a reference scan for a sequence of pseudo-random request patterns that span both banks. A design that scanned in the wrong direction, or that ignored the valid flag, would report a lower-precedence or stale source.

Targeted cases check three things: a source routed to the fast path or disabled must drop out of the scan, a request whose only slot is invalid must leave the status at zero while irq_o stays high, and the status must change exactly one cycle after an input change. A missing register stage would show the new value one cycle early, and an extra stage would show it one cycle late.

Further cases cover wake in both modes, writes to read-only offsets, unmapped and misaligned reads, and the release of a source input. These expose bus decodes that corrupt the enable bits and pending state that latches where it should follow the level.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;
  localparam int ADDR_W      = 9;
  localparam int MAX_SRC     = 64;
  localparam int SRC_W       = 6;
  localparam int BANK_W      = 32;
  localparam int BANK_STRIDE = 'h9C;

  // per-bank offsets (R2)
  localparam logic [ADDR_W-1:0] OFS_IRQ   = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_STEER = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_FIQ   = 9'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 9'h010;
  // single registers
  localparam logic [ADDR_W-1:0] A_CTRL    = 9'h014;
  localparam logic [ADDR_W-1:0] A_STAT    = 9'h018;
  // priority slot windows (R5)
  localparam logic [ADDR_W-1:0] PRIO_LO   = 9'h01C;
  localparam logic [ADDR_W-1:0] PRIO_HI   = 9'h0B0;
  localparam logic [ADDR_W-1:0] PRIO_SPAN = 9'h080;

  typedef struct packed {
    logic             vld;
    logic [SRC_W-1:0] num;
  } prio_ent_t;

  function automatic logic bank_hit(logic [ADDR_W-1:0] a, int b,
                                    logic [ADDR_W-1:0] ofs);
    return a == (ADDR_W'(b * BANK_STRIDE) + ofs);
  endfunction

  // {hit, slot}: hit set when a is an aligned priority slot address
  function automatic logic [SRC_W:0] slot_dec(logic [ADDR_W-1:0] a);
    slot_dec = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= PRIO_LO && a < PRIO_LO + PRIO_SPAN)
        slot_dec = {2'b10, 5'((a - PRIO_LO) >> 2)};
      else if (a >= PRIO_HI && a < PRIO_HI + PRIO_SPAN)
        slot_dec = {2'b11, 5'((a - PRIO_HI) >> 2)};
    end
  endfunction

  function automatic logic slot_ok(logic [SRC_W:0] sd, int n);
    return sd[SRC_W] && (int'(sd[SRC_W-1:0]) < n);
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
`timescale 1ns/1ps
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int NBANK  = NSRC / BANK_W,
  localparam int SLOT_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [NSRC-1:0]        mask,
  output logic [NSRC-1:0]        steer,
  output logic                   wake_masked,
  output prio_ent_t [NSRC-1:0]   ent
);
  logic [SRC_W:0] sd;
  logic           sd_hit;

  assign sd     = slot_dec(bus_addr);
  assign sd_hit = slot_ok(sd, NSRC);

  // R1 reset, R2 enable/routing writes, R5 slot writes, R9 wake mode.
  // Read-only offsets have no branch here (R10).
  always_ff @(posedge clk) begin
    if (rst) begin
      mask        <= '0;
      steer       <= '0;
      wake_masked <= 1'b0;
      ent         <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_hit(bus_addr, b, OFS_MASK))
          mask[b*BANK_W +: BANK_W] <= bus_wdata;
        if (bank_hit(bus_addr, b, OFS_STEER))
          steer[b*BANK_W +: BANK_W] <= bus_wdata;
      end
      if (bus_addr == A_CTRL)
        wake_masked <= bus_wdata[0];
      if (sd_hit)
        ent[sd[SLOT_W-1:0]] <= {bus_wdata[31], bus_wdata[SRC_W-1:0]};
    end
  end
endmodule

// File: rtl/prio_intc_scan.sv
`timescale 1ns/1ps
module prio_intc_scan
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  prio_ent_t [NSRC-1:0] ent,
  input  logic [NSRC-1:0]      irq_pend,
  output logic                 hit,
  output logic [SRC_W-1:0]     win
);
  logic [MAX_SRC-1:0] pend_ext;
  assign pend_ext = MAX_SRC'(irq_pend);

  // R6/R7: scan from the lowest-precedence slot upward so the lowest
  // qualifying index is the last assignment and wins.
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (ent[s].vld && pend_ext[ent[s].num]) begin
        hit = 1'b1;
        win = ent[s].num;
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  localparam int NBANK  = NSRC / BANK_W;
  localparam int SLOT_W = $clog2(NSRC);

  logic [NSRC-1:0]      mask;
  logic [NSRC-1:0]      steer;
  logic                 wake_masked;
  prio_ent_t [NSRC-1:0] ent;
  logic [NSRC-1:0]      irq_pend;
  logic [NSRC-1:0]      fiq_pend;
  logic                 hit;
  logic [SRC_W-1:0]     win;
  logic [31:0]          stat_q;
  logic [31:0]          rd_word;
  logic [SRC_W:0]       sd;

  prio_intc_regs #(.NSRC(NSRC)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .mask       (mask),
    .steer      (steer),
    .wake_masked(wake_masked),
    .ent        (ent)
  );

  // R3 pending split
  assign irq_pend = src_lvl & mask & ~steer;
  assign fiq_pend = src_lvl & mask & steer;

  prio_intc_scan #(.NSRC(NSRC)) scan_i (
    .ent     (ent),
    .irq_pend(irq_pend),
    .hit     (hit),
    .win     (win)
  );

  assign sd = slot_dec(bus_addr);

  // R2/R5/R10 read decode
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_hit(bus_addr, b, OFS_IRQ))   rd_word = irq_pend[b*BANK_W +: BANK_W];
      if (bank_hit(bus_addr, b, OFS_MASK))  rd_word = mask[b*BANK_W +: BANK_W];
      if (bank_hit(bus_addr, b, OFS_STEER)) rd_word = steer[b*BANK_W +: BANK_W];
      if (bank_hit(bus_addr, b, OFS_FIQ))   rd_word = fiq_pend[b*BANK_W +: BANK_W];
      if (bank_hit(bus_addr, b, OFS_RAW))   rd_word = src_lvl[b*BANK_W +: BANK_W];
    end
    if (bus_addr == A_CTRL) rd_word = {31'b0, wake_masked};
    if (bus_addr == A_STAT) rd_word = stat_q;
    if (slot_ok(sd, NSRC))
      rd_word = {ent[sd[SLOT_W-1:0]].vld, {(31-SRC_W){1'b0}},
                 ent[sd[SLOT_W-1:0]].num};
  end

  // R4, R8, R9 registered outputs; R1 reset values
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      wake_o    <= 1'b0;
      stat_q    <= '0;
      bus_rdata <= '0;
    end else begin
      irq_o     <= |irq_pend;
      fiq_o     <= |fiq_pend;
      wake_o    <= wake_masked ? |(src_lvl & mask) : |src_lvl;
      stat_q    <= hit ? {1'b1, {(15-SRC_W){1'b0}}, win, 16'h0000} : 32'h0;
      bus_rdata <= bus_rd ? rd_word : 32'h0;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
`timescale 1ns/1ps
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_lvl,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              wake_o,
  input logic [NSRC-1:0]   mask,
  input logic [NSRC-1:0]   steer,
  input logic [31:0]       stat_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !fiq_o && !wake_o && stat_q == 32'h0));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == '0) |-> (!irq_o && !fiq_o));

  assert_status_needs_irq_R6: assert property (@(posedge clk) disable iff (rst)
    stat_q[31] |-> irq_o);

  assert_fast_never_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(steer) == {NSRC{1'b1}}) |-> !stat_q[31]);

  assert_wake_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(|src_lvl) |-> !wake_o);

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == OFS_IRQ || bus_addr == OFS_RAW || bus_addr == A_STAT))
      |=> ($stable(mask) && $stable(steer)));

  assert_level_release_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(|src_lvl) |-> (!irq_o && !fiq_o));
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .src_lvl (src_lvl),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .wake_o  (wake_o),
  .mask    (mask),
  .steer   (steer),
  .stat_q  (stat_q)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  localparam int NSRC = 64;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_lvl = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  always #(CLK_P/2) clk = ~clk;

  prio_intc #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] exp;
    logic [8:0]  addr;
    string       tag;
  } item_t;
  item_t sbq[$];

  // reference model state
  logic [63:0] m_mask  = '0;
  logic [63:0] m_steer = '0;
  logic        pv[64];
  logic [5:0]  pn[64];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(logic [63:0] raw);
    logic [63:0] ip;
    logic        h;
    logic [5:0]  w;
    ip = raw & m_mask & ~m_steer;
    h = 1'b0;
    w = '0;
    for (int s = 63; s >= 0; s--)
      if (pv[s] && ip[pn[s]]) begin h = 1'b1; w = pn[s]; end
    return h ? {1'b1, 9'b0, w, 16'h0} : 32'h0;
  endfunction

  task automatic bus_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_exp(logic [8:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    sbq.push_back('{exp, a, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // read issued in the same cycle as an input change
  task automatic read_with_src(logic [63:0] s, logic [8:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    src_lvl = s;
    bus_rd = 1'b1; bus_addr = a;
    sbq.push_back('{exp, a, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_src(logic [63:0] v);
    @(negedge clk);
    src_lvl = v;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_mask(int b, logic [31:0] v);
    bus_write(b ? 9'h0A0 : 9'h004, v);
    m_mask[b*32 +: 32] = v;
  endtask

  task automatic set_steer(int b, logic [31:0] v);
    bus_write(b ? 9'h0A4 : 9'h008, v);
    m_steer[b*32 +: 32] = v;
  endtask

  function automatic logic [8:0] slot_addr(int s);
    return (s < 32) ? 9'(32'h1C + 4*s) : 9'(32'hB0 + 4*(s-32));
  endfunction

  task automatic set_prio(int s, logic v, logic [5:0] n, logic [24:0] junk);
    bus_write(slot_addr(s), {v, junk, n});
    pv[s] = v;
    pn[s] = n;
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sbq.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: read result with no expected item");
        end else begin
          it = sbq.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [63:0] lf;
    logic [63:0] v;
    for (int s = 0; s < 64; s++) begin pv[s] = 1'b0; pn[s] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    check("R1 wake_o", {31'b0, wake_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read_exp(9'h004, 32'h0, "R1 enable bank0");
    bus_read_exp(9'h0A0, 32'h0, "R1 enable bank1");
    bus_read_exp(9'h008, 32'h0, "R1 routing bank0");
    bus_read_exp(9'h014, 32'h0, "R1 control");
    bus_read_exp(9'h018, 32'h0, "R1 status");
    bus_read_exp(9'h01C, 32'h0, "R1 slot0");
    bus_read_exp(9'h12C, 32'h0, "R1 slot63");

    // R2 register map and readback
    set_mask(0, 32'hA5A5_0F0F);
    bus_read_exp(9'h004, 32'hA5A5_0F0F, "R2 enable bank0");
    set_mask(1, 32'h1234_5678);
    bus_read_exp(9'h0A0, 32'h1234_5678, "R2 enable bank1");
    set_steer(1, 32'h0F0F_0000);
    bus_read_exp(9'h0A4, 32'h0F0F_0000, "R2 routing bank1");
    set_steer(0, 32'h0000_00F0);
    bus_read_exp(9'h008, 32'h0000_00F0, "R2 routing bank0");

    // R3 pending split, both banks
    v = 64'h3C0F_F00F_C3C3_00FF;
    set_src(v);
    bus_read_exp(9'h010, v[31:0], "R3 raw bank0");
    bus_read_exp(9'h0AC, v[63:32], "R3 raw bank1");
    bus_read_exp(9'h000, v[31:0] & m_mask[31:0] & ~m_steer[31:0], "R3 normal bank0");
    bus_read_exp(9'h00C, v[31:0] & m_mask[31:0] & m_steer[31:0], "R3 fast bank0");
    bus_read_exp(9'h09C, v[63:32] & m_mask[63:32] & ~m_steer[63:32], "R3 normal bank1");
    bus_read_exp(9'h0A8, v[63:32] & m_mask[63:32] & m_steer[63:32], "R3 fast bank1");

    // R4 output OR with one cycle of delay
    set_mask(0, 32'h0); set_mask(1, 32'h0); set_steer(0, 32'h0); set_steer(1, 32'h0);
    set_src(64'h0000_0100_0000_0010);
    settle();
    check("R4 irq_o all disabled", {31'b0, irq_o}, 32'h0);
    set_steer(1, 32'h0000_0100);
    set_mask(1, 32'h0000_0100);
    settle();
    check("R4 fiq_o routed fast", {31'b0, fiq_o}, 32'h1);
    check("R4 irq_o routed fast", {31'b0, irq_o}, 32'h0);
    bus_write(9'h004, 32'h0000_0010);
    m_mask[31:0] = 32'h0000_0010;
    check("R4 irq_o before edge", {31'b0, irq_o}, 32'h0);
    settle();
    check("R4 irq_o one cycle later", {31'b0, irq_o}, 32'h1);

    // R5 slot placement and format
    set_prio(0, 1'b1, 6'd5, 25'h1FF_FFFF);
    bus_read_exp(9'h01C, {1'b1, 25'h0, 6'd5}, "R5 slot0");
    set_prio(33, 1'b1, 6'd44, 25'h0AA_AAAA);
    bus_read_exp(9'h0B4, {1'b1, 25'h0, 6'd44}, "R5 slot33");
    set_prio(63, 1'b0, 6'd63, 25'h0);
    bus_read_exp(9'h12C, {1'b0, 25'h0, 6'd63}, "R5 slot63");
    set_prio(31, 1'b1, 6'd7, 25'h0);
    bus_read_exp(9'h098, {1'b1, 25'h0, 6'd7}, "R5 slot31");

    // R6 priority scan
    for (int s = 0; s < 64; s++) set_prio(s, 1'b1, 6'(63 - s), 25'h0);
    set_prio(2, 1'b1, 6'd10, 25'h0);
    set_prio(5, 1'b0, 6'd20, 25'h0);
    set_mask(0, 32'hFFFF_FFFF); set_mask(1, 32'hFFFF_FFFF);
    set_steer(0, 32'h0); set_steer(1, 32'h0);
    set_src(64'h0000_0100_0000_0008);
    bus_read_exp(9'h018, {1'b1, 9'b0, 6'd40, 16'h0}, "R6 two-source winner");
    set_src(64'h0000_0100_0000_0408);
    bus_read_exp(9'h018, {1'b1, 9'b0, 6'd10, 16'h0}, "R6 rewritten slot winner");
    lf = 64'hACE1_2468_9BDF_1357;
    for (int k = 0; k < 10; k++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      v = lf & {$random, $random};
      set_src(v);
      bus_read_exp(9'h018, exp_stat(v), "R6 pattern scan");
    end

    // R7 exclusions
    set_src(64'h0000_0100_0000_0008);
    set_steer(1, 32'h0000_0100);
    bus_read_exp(9'h018, {1'b1, 9'b0, 6'd3, 16'h0}, "R7 fast source skipped");
    set_prio(60, 1'b0, 6'd3, 25'h0);
    bus_read_exp(9'h018, 32'h0, "R7 invalid slot skipped");
    check("R7 irq_o still set", {31'b0, irq_o}, 32'h1);
    set_prio(60, 1'b1, 6'd3, 25'h0);
    set_mask(0, 32'hFFFF_FFF7);
    bus_read_exp(9'h018, 32'h0, "R7 disabled source skipped");
    set_mask(0, 32'hFFFF_FFFF);

    // R8 registered status
    set_src(64'h0);
    settle();
    read_with_src(64'h0000_0000_0000_0008, 9'h018, 32'h0, "R8 status old in change cycle");
    bus_read_exp(9'h018, {1'b1, 9'b0, 6'd3, 16'h0}, "R8 status new next cycle");

    // R9 wake modes
    set_mask(0, 32'h0); set_mask(1, 32'h0);
    set_src(64'h0000_0000_0000_0020);
    settle();
    check("R9 wake any raw", {31'b0, wake_o}, 32'h1);
    bus_write(9'h014, 32'h1);
    bus_read_exp(9'h014, 32'h1, "R9 control readback");
    check("R9 wake masked mode disabled src", {31'b0, wake_o}, 32'h0);
    set_mask(0, 32'h0000_0020);
    settle();
    check("R9 wake masked mode enabled src", {31'b0, wake_o}, 32'h1);
    set_src(64'h0);
    settle();
    check("R9 wake no request", {31'b0, wake_o}, 32'h0);

    // R10 read-only writes and unmapped reads
    set_src(64'h0000_0000_0000_0020);
    bus_write(9'h000, 32'hFFFF_FFFF);
    bus_read_exp(9'h004, 32'h0000_0020, "R10 write to pending ignored");
    bus_write(9'h010, 32'h0);
    bus_read_exp(9'h010, 32'h0000_0020, "R10 write to raw ignored");
    bus_write(9'h018, 32'h0);
    bus_read_exp(9'h018, exp_stat(64'h20), "R10 write to status ignored");
    bus_read_exp(9'h130, 32'h0, "R10 unmapped 0x130");
    bus_read_exp(9'h1FC, 32'h0, "R10 unmapped 0x1FC");
    bus_read_exp(9'h01E, 32'h0, "R10 misaligned slot address");

    // R11 level following
    bus_write(9'h014, 32'h0);
    set_mask(0, 32'h0000_0008); set_steer(0, 32'h0);
    set_src(64'h8);
    settle();
    check("R11 irq_o high", {31'b0, irq_o}, 32'h1);
    set_src(64'h0);
    settle();
    check("R11 irq_o drops", {31'b0, irq_o}, 32'h0);
    bus_read_exp(9'h000, 32'h0, "R11 pending clears");
    set_src(64'h8);
    bus_read_exp(9'h000, 32'h8, "R11 pending returns");

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    finish_run();
  end
endmodule